// File: doc/BRIEF.md
# Burst Address Sequencer for a Pipelined Synchronous SRAM

This block produces the address for each access of a short burst in a synchronous SRAM. A caller loads a start address once. Each later advance strobe then gives the next address of the burst, with no need to present the address bus again. Only the low two address bits move. Their order is either linear or interleaved, as chosen by a mode pin, and they wrap after four beats. The upper bits are held for the whole burst.

The block also records whether the burst is a read, a write or no access at all. This type is decided at the load and does not change while the burst advances. Advancing does not look at the chip select or the write enable. A clock enable, active low, freezes all state when it is high.

A small state machine holds the access type. Its states are `ST_IDLE` (deselected), `ST_READ` and `ST_WRITE`. Each enabled edge is decoded into one event:

- `EV_STALL`: clock enable high. The state holds.
- `EV_ADVANCE`: step the beat. The state holds.
- `EV_LOAD_RD`: load a selected read. Go to `ST_READ`.
- `EV_LOAD_WR`: load a selected write. Go to `ST_WRITE`.
- `EV_LOAD_DESEL`: load with the chip deselected. Go to `ST_IDLE`.

Any of the three load events can be taken from any state.

Top module: `burst_seq`

## Requirements
- R1: After reset, acc_valid and acc_write are 0 and acc_addr is 0.
- R2: At a rising edge with cke_n=0 and advance=0, the block loads addr_in. From the next cycle, acc_addr equals the loaded address, acc_valid equals chip_sel, and acc_write equals chip_sel AND wr_en.
- R3: With order_mode=0 (linear), acc_addr[1:0] equals (start + n) mod 4 after n advances, where start is the loaded value of addr_in[1:0].
- R4: With order_mode=1 (interleaved), acc_addr[1:0] equals start XOR n after n advances.
- R5: acc_addr[ADDR_W-1:2] keeps the loaded value through every advance.
- R6: The beat count wraps. After four advances, acc_addr returns to the loaded address.
- R7: An advance (cke_n=0, advance=1) leaves acc_valid and acc_write unchanged, whatever chip_sel and wr_en are.
- R8: While cke_n=1, acc_addr, acc_valid and acc_write hold their values, whatever advance, chip_sel, wr_en and addr_in are.
- R9: A burst loaded with chip_sel=0 keeps acc_valid=0 and acc_write=0 through all its advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; high freezes all state |
| advance | input | 1 | 1 = step the burst, 0 = load a new address |
| chip_sel | input | 1 | All chip enables asserted (sampled at load only) |
| wr_en | input | 1 | 1 = write, 0 = read (sampled at load only) |
| order_mode | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_in | input | ADDR_W | Address presented at a load |
| acc_addr | output | ADDR_W | Address of the current beat |
| acc_valid | output | 1 | An access is active for this beat |
| acc_write | output | 1 | The active access is a write |

## Verification
The linear-step and stall-hold assertions assume that order_mode stays constant across the edge being checked, because acc_addr follows the mode pin combinationally. Both properties therefore hold only when the mode is stable, and the stimulus changes order_mode only immediately before a load. Every other assertion makes no assumption about chip_sel, wr_en or addr_in. To show that those inputs are ignored while advancing or stalled, the stimulus deliberately drives them to values opposite to the loaded ones.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } burst_state_e;

    typedef enum logic [2:0] {
        EV_STALL      = 3'd0,
        EV_ADVANCE    = 3'd1,
        EV_LOAD_RD    = 3'd2,
        EV_LOAD_WR    = 3'd3,
        EV_LOAD_DESEL = 3'd4
    } burst_event_e;

endpackage

// File: rtl/burst_evt_decode.sv
module burst_evt_decode
    import burst_seq_pkg::*;
(
    input  logic         cke_n,
    input  logic         advance,
    input  logic         chip_sel,
    input  logic         wr_en,
    output burst_event_e evt
);

    always_comb begin
        if (cke_n) begin
            evt = EV_STALL;
        end else if (advance) begin
            // stepping never samples the select or the write enable
            evt = EV_ADVANCE;
        end else if (!chip_sel) begin
            evt = EV_LOAD_DESEL;
        end else if (wr_en) begin
            evt = EV_LOAD_WR;
        end else begin
            evt = EV_LOAD_RD;
        end
    end

endmodule

// File: rtl/burst_ctrl_fsm.sv
module burst_ctrl_fsm
    import burst_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  burst_event_e evt,
    output logic         load_pulse,
    output logic         step_pulse,
    output logic         acc_valid,
    output logic         acc_write
);

    burst_state_e state_q;
    burst_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (evt)
            EV_LOAD_RD:    state_d = ST_READ;
            EV_LOAD_WR:    state_d = ST_WRITE;
            EV_LOAD_DESEL: state_d = ST_IDLE;
            EV_ADVANCE:    state_d = state_q;
            EV_STALL:      state_d = state_q;
            default:       state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load_pulse = 1'b0;
        step_pulse = 1'b0;
        acc_valid  = 1'b0;
        acc_write  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                acc_valid = 1'b0;
                acc_write = 1'b0;
            end
            ST_READ: begin
                acc_valid = 1'b1;
                acc_write = 1'b0;
            end
            ST_WRITE: begin
                acc_valid = 1'b1;
                acc_write = 1'b1;
            end
            default: begin
                acc_valid = 1'b0;
                acc_write = 1'b0;
            end
        endcase
        unique case (evt)
            EV_LOAD_RD, EV_LOAD_WR, EV_LOAD_DESEL: load_pulse = 1'b1;
            EV_ADVANCE:                            step_pulse = 1'b1;
            default: begin
                load_pulse = 1'b0;
                step_pulse = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int ADDR_W     = 18,
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_pulse,
    input  logic                  step_pulse,
    input  logic [ADDR_W-1:0]     addr_in,
    output logic [ADDR_W-1:0]     base_q,
    output logic [BURST_BITS-1:0] beat_q
);

    localparam logic [BURST_BITS-1:0] BEAT_ONE = BURST_BITS'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (load_pulse) begin
            base_q <= addr_in;
            beat_q <= '0;
        end else if (step_pulse) begin
            // natural wrap of a BURST_BITS-wide count
            beat_q <= beat_q + BEAT_ONE;
        end
    end

endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen #(
    parameter int BURST_BITS = 2
) (
    input  logic [BURST_BITS-1:0] start_lo,
    input  logic [BURST_BITS-1:0] beat,
    input  logic                  order_mode,
    output logic [BURST_BITS-1:0] seq_lo
);

    logic [BURST_BITS-1:0] lin_lo;
    logic [BURST_BITS-1:0] ilv_lo;

    assign lin_lo = start_lo + beat;

    for (genvar b = 0; b < BURST_BITS; b++) begin : g_ilv
        assign ilv_lo[b] = start_lo[b] ^ beat[b];
    end

    assign seq_lo = order_mode ? ilv_lo : lin_lo;

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              advance,
    input  logic              chip_sel,
    input  logic              wr_en,
    input  logic              order_mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_valid,
    output logic              acc_write
);

    localparam int UPPER_W = ADDR_W - BURST_BITS;

    burst_event_e          evt;
    logic                  load_pulse;
    logic                  step_pulse;
    logic [ADDR_W-1:0]     base_q;
    logic [BURST_BITS-1:0] beat_q;
    logic [BURST_BITS-1:0] seq_lo;

    burst_evt_decode u_dec (
        .cke_n    (cke_n),
        .advance  (advance),
        .chip_sel (chip_sel),
        .wr_en    (wr_en),
        .evt      (evt)
    );

    burst_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .load_pulse (load_pulse),
        .step_pulse (step_pulse),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write)
    );

    burst_beat_ctr #(
        .ADDR_W     (ADDR_W),
        .BURST_BITS (BURST_BITS)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_pulse (load_pulse),
        .step_pulse (step_pulse),
        .addr_in    (addr_in),
        .base_q     (base_q),
        .beat_q     (beat_q)
    );

    burst_order_gen #(
        .BURST_BITS (BURST_BITS)
    ) u_ord (
        .start_lo   (base_q[BURST_BITS-1:0]),
        .beat       (beat_q),
        .order_mode (order_mode),
        .seq_lo     (seq_lo)
    );

    assign acc_addr = {base_q[ADDR_W-1:BURST_BITS], seq_lo};

    initial begin
        if (UPPER_W < 1) $error("ADDR_W must exceed BURST_BITS");
    end

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int ADDR_W     = 18,
    parameter int BURST_BITS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_n,
    input logic              advance,
    input logic              chip_sel,
    input logic              order_mode,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_valid,
    input logic              acc_write
);

    logic [BURST_BITS-1:0]        lo_now;
    logic [ADDR_W-BURST_BITS-1:0] hi_now;

    assign lo_now = acc_addr[BURST_BITS-1:0];
    assign hi_now = acc_addr[ADDR_W-1:BURST_BITS];

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !advance) |=> acc_addr == $past(addr_in)); // R2

    AST_LOAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !advance) |=> acc_valid == $past(chip_sel)); // R2

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && advance && !order_mode) |=>
        (order_mode || lo_now == $past(lo_now) + BURST_BITS'(1))); // R3

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && advance) |=> hi_now == $past(hi_now)); // R5

    AST_ADV_KEEP_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && advance) |=> ($stable(acc_valid) && $stable(acc_write))); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(acc_valid) && $stable(acc_write)
                   && (!$stable(order_mode) || $stable(acc_addr)))); // R8

    AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        acc_write |-> acc_valid); // R9

endmodule

bind burst_seq burst_seq_chk #(
    .ADDR_W     (ADDR_W),
    .BURST_BITS (BURST_BITS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke_n      (cke_n),
    .advance    (advance),
    .chip_sel   (chip_sel),
    .order_mode (order_mode),
    .addr_in    (addr_in),
    .acc_addr   (acc_addr),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write)
);

// File: tb/burst_seq_tb_top.sv
module burst_seq_tb_top;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b1;
    logic          advance = 1'b0;
    logic          chip_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic          order_mode = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] acc_addr;
    logic          acc_valid;
    logic          acc_write;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    burst_seq #(.ADDR_W(AW), .BURST_BITS(2)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke_n      (cke_n),
        .advance    (advance),
        .chip_sel   (chip_sel),
        .wr_en      (wr_en),
        .order_mode (order_mode),
        .addr_in    (addr_in),
        .acc_addr   (acc_addr),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write)
    );

    task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, sample shortly after the next rising edge
    task automatic cyc(input logic ck, input logic adv, input logic sel, input logic we,
                       input logic [AW-1:0] a);
        @(negedge clk);
        cke_n = ck; advance = adv; chip_sel = sel; wr_en = we; addr_in = a;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [1:0] exp_lo(input logic m, input logic [1:0] s, input logic [1:0] n);
        return m ? (s ^ n) : (s + n);
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        check(acc_valid == 1'b0, "R1 valid", AW'(acc_valid), '0);
        check(acc_write == 1'b0, "R1 write", AW'(acc_write), '0);
        check(acc_addr == '0, "R1 addr", acc_addr, '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_burst(input logic m, input logic [1:0] s, input logic we);
        logic [AW-1:0] base;
        base = {16'h5A3C ^ {14'd0, s, m, we}, s};
        @(negedge clk);
        order_mode = m;
        cyc(1'b0, 1'b0, 1'b1, we, base);
        check(acc_addr == base, "R2 load addr", acc_addr, base);
        check(acc_valid == 1'b1, "R2 valid", AW'(acc_valid), AW'(1));
        check(acc_write == we, "R2 write", AW'(acc_write), AW'(we));
        for (int n = 1; n <= 4; n++) begin
            logic [AW-1:0] e;
            // R7: select dropped and write enable flipped while advancing
            cyc(1'b0, 1'b1, 1'b0, ~we, ~base);
            e = {base[AW-1:2], exp_lo(m, s, 2'(n))};
            if (n == 4) check(acc_addr == base, "R6 wrap", acc_addr, base);
            else if (m) check(acc_addr[1:0] == e[1:0], "R4 interleaved", acc_addr, e);
            else check(acc_addr[1:0] == e[1:0], "R3 linear", acc_addr, e);
            check(acc_addr[AW-1:2] == base[AW-1:2], "R5 upper", acc_addr, e);
            check(acc_valid == 1'b1 && acc_write == we, "R7 type kept",
                  AW'({acc_valid, acc_write}), AW'({1'b1, we}));
        end
    endtask

    task automatic t_stall();
        logic [AW-1:0] base;
        logic [AW-1:0] e;
        base = 18'h2_1F02;
        @(negedge clk);
        order_mode = 1'b0;
        cyc(1'b0, 1'b0, 1'b1, 1'b0, base);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, base);
        e = {base[AW-1:2], 2'd3};
        for (int k = 0; k < 3; k++) begin
            cyc(1'b1, k[0], 1'b1, 1'b1, 18'h3_FFFF);
            check(acc_addr == e, "R8 stall addr", acc_addr, e);
            check(acc_valid == 1'b1 && acc_write == 1'b0, "R8 stall type",
                  AW'({acc_valid, acc_write}), AW'(2'b10));
        end
        cyc(1'b0, 1'b1, 1'b0, 1'b1, '0);
        e = {base[AW-1:2], 2'd0};
        check(acc_addr == e, "R8 resume R3", acc_addr, e);
    endtask

    task automatic t_desel();
        logic [AW-1:0] base;
        base = 18'h1_2345;
        @(negedge clk);
        order_mode = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 1'b1, base);
        check(acc_valid == 1'b0 && acc_write == 1'b0, "R9 desel load",
              AW'({acc_valid, acc_write}), '0);
        for (int n = 1; n <= 3; n++) begin
            cyc(1'b0, 1'b1, 1'b1, 1'b1, base);
            check(acc_valid == 1'b0 && acc_write == 1'b0, "R9 desel advance",
                  AW'({acc_valid, acc_write}), '0);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                t_burst(m[0], 2'(s), s[0]);
            end
        end
        t_stall();
        t_desel();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule